// File: doc/BRIEF.md
# Z80 Memory-Map Chip-Select Decoder

This block turns the top five address bits of a Z80 bus, together with its active-low memory-request, I/O-request, read, write and opcode-fetch strobes, into the active-low chip selects of a small home-computer memory map. The low 32K holds two 8K ROMs, a cartridge window, a 2K memory-mapped I/O window, a 2K video RAM and the first 2K of user RAM. Above 7FFF only the next 16K is decoded, as eight 2K RAM selects. The region C000 to FFFF is left with no select at all, so that banking hardware can claim it.

The I/O window does not produce a plain select. It produces separate read and write strobes qualified by the CPU read and write lines. The video RAM has a plain select, which gates the video generator off the shared RAM, and a separate write strobe. The write strobe is qualified one clock later than the select, so it never leads the select. A parameter chooses between combinational outputs and one registered output stage. The register stage is on by default.

Top module: `mem_cs_decoder`

## Requirements
- R1: No select or strobe is active unless the cycle is a memory cycle (`mreq_n` low and `iorq_n` high). An idle bus or an I/O-request cycle leaves every output high.
- R2: Address 0000–1FFF (A15..A13 = 000) drives `rom0_cs_n` low. Address 2000–3FFF (A15..A13 = 001) drives `rom1_cs_n` low.
- R3: Address 4000–67FF (A15..A11 = 01000 through 01100) drives `cart_cs_n` low.
- R4: In the I/O window 6800–6FFF (A15..A11 = 01101), `mmio_rd_n` is low only when `rd_n` is low and `mmio_wr_n` is low only when `wr_n` is low. With neither strobe low, neither output is active.
- R5: Address 7000–77FF (A15..A11 = 01110) drives `vram_cs_n` low in any memory cycle. Address 7800–7FFF (A15..A11 = 01111) drives `ram_lo_cs_n` low.
- R6: Address 8000–BFFF drives bit i of `ram_hi_cs_n` low, where i = A13..A11. This is granule 8000 + i·0800.
- R7: Address C000–FFFF (A15..A14 = 11) drives no output low.
- R8: `vram_wr_n` is low only while `vram_cs_n` is low, `wr_n` is low and the video window was also decoded in the previous clock. On the first clock of a video write only `vram_cs_n` is active.
- R9: An opcode fetch (`m1_n` low with `rd_n` low) decodes exactly like a memory read of the same address.
- R10: At most one of the selects is active at a time. The two I/O strobes count as one select, and the video select and video write count as one.
- R11: With `REG_OUT` = 1 the outputs show the decode of the inputs sampled at the previous rising edge. A synchronous active-low reset drives every output high and clears the video write history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output stage and the video write history |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_hi | input | 5 | Address bits A15..A11 (bit 4 = A15) |
| mreq_n | input | 1 | Memory request, active low |
| iorq_n | input | 1 | I/O request, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| m1_n | input | 1 | Opcode fetch marker, active low |
| rom0_cs_n | output | 1 | ROM 0 select, 0000–1FFF |
| rom1_cs_n | output | 1 | ROM 1 select, 2000–3FFF |
| cart_cs_n | output | 1 | Cartridge select, 4000–67FF |
| mmio_rd_n | output | 1 | I/O window read strobe, 6800–6FFF |
| mmio_wr_n | output | 1 | I/O window write strobe, 6800–6FFF |
| vram_cs_n | output | 1 | Video RAM select, 7000–77FF |
| vram_wr_n | output | 1 | Qualified video RAM write strobe |
| ram_lo_cs_n | output | 1 | User RAM select, 7800–7FFF |
| ram_hi_cs_n | output | 8 | User RAM 2K selects, 8000–BFFF |

## Verification
The video select and the video write strobe are the two functions that share a cycle. The bench provokes this by holding every address and cycle type for two consecutive clocks. For a write to 7000–77FF, the first clock must show the select alone and the second clock must show the select and the write strobe together. A reset placed in the middle of a held video write must restart that one-clock lag. A behavioural reference model tracks the previous cycle's window and is compared against all outputs on every clock.

// File: rtl/mcd_pkg.sv
// Package: shared constants and types for the memory-map chip-select decoder.
// Assumes the address tag is A15..A11, so one tag value covers one 2K granule.
package mcd_pkg;

    localparam int TAG_W     = 5;               // A15..A11
    localparam int BLK_N     = 4;               // 8K blocks in the low 32K
    localparam int HI_GRAN   = 8;               // 2K granules in 8000-BFFF
    localparam int HI_GRAN_W = $clog2(HI_GRAN);
    localparam int OUT_W     = 8 + HI_GRAN;     // packed width of all outputs

    // Kind of bus cycle seen on the strobes
    typedef enum logic [2:0] {
        CYC_IDLE,
        CYC_READ,
        CYC_FETCH,
        CYC_WRITE,
        CYC_REFRESH,
        CYC_NONMEM
    } cyc_e;

    // Decoded windows, active high inside the block
    typedef struct packed {
        logic               rom0;
        logic               rom1;
        logic               cart;
        logic               mmio;
        logic               vram;
        logic               ram_lo;
        logic [HI_GRAN-1:0] ram_hi;
    } sel_t;

endpackage

// File: rtl/mcd_block_decode.sv
// Module: first decode stage. It classifies the bus cycle and splits the
// address space into the four low 8K blocks and the upper half.
// Assumes: /MREQ low with /IORQ high marks a memory cycle; /M1 only tags a fetch.
module mcd_block_decode
    import mcd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TAG_W-1:0] addr_hi,
    input  logic             mreq_n,
    input  logic             iorq_n,
    input  logic             rd_n,
    input  logic             wr_n,
    input  logic             m1_n,
    output cyc_e             cyc,
    output logic [BLK_N-1:0] blk_en,
    output logic             up_en
);

    logic mem_go;

    // Purpose: name the cycle from the raw strobes
    always_comb begin
        if (mreq_n)
            cyc = iorq_n ? CYC_IDLE : CYC_NONMEM;
        else if (!iorq_n)
            cyc = CYC_NONMEM;
        else if (!wr_n)
            cyc = CYC_WRITE;
        else if (!rd_n)
            cyc = m1_n ? CYC_READ : CYC_FETCH;
        else
            cyc = CYC_REFRESH;
    end

    // Purpose: any memory cycle opens the decoder; a fetch counts like a read
    always_comb begin
        mem_go = (cyc == CYC_READ) || (cyc == CYC_FETCH) ||
                 (cyc == CYC_WRITE) || (cyc == CYC_REFRESH);
    end

    // Purpose: A15 combined with the memory gate selects one low 8K block
    for (genvar b = 0; b < BLK_N; b++) begin : g_blk
        assign blk_en[b] = mem_go && !addr_hi[TAG_W-1] &&
                           (addr_hi[TAG_W-2 -: 2] == 2'(b));
    end

    // Purpose: the upper half opens only in a memory cycle
    assign up_en = mem_go && addr_hi[TAG_W-1];

    // R1: a cycle without a memory request never opens any block
    assert_gate_closed_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mreq_n || !iorq_n) |-> (blk_en == '0 && !up_en));

    // R9: a fetch opens the same block as a read would
    assert_fetch_opens_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!mreq_n && iorq_n && !rd_n && !m1_n && !addr_hi[TAG_W-1]) |-> $onehot(blk_en));

endmodule

// File: rtl/mcd_sub_decode.sv
// Module: second decode stage. It splits the top low 8K block into 2K windows
// and the upper half into 2K RAM granules.
// Assumes: blk_en and up_en are already gated by the memory cycle.
module mcd_sub_decode
    import mcd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TAG_W-1:0] addr_hi,
    input  logic [BLK_N-1:0] blk_en,
    input  logic             up_en,
    output sel_t             sel
);

    logic [1:0] sub;

    assign sub = addr_hi[1:0];

    // Purpose: map the low blocks and 2K windows of 6000-7FFF
    always_comb begin
        sel.rom0   = blk_en[0];
        sel.rom1   = blk_en[1];
        sel.cart   = blk_en[2] || (blk_en[3] && sub == 2'b00);
        sel.mmio   = blk_en[3] && sub == 2'b01;
        sel.vram   = blk_en[3] && sub == 2'b10;
        sel.ram_lo = blk_en[3] && sub == 2'b11;
    end

    // Purpose: one RAM granule per 2K in 8000-BFFF; A14 high leaves it open
    for (genvar g = 0; g < HI_GRAN; g++) begin : g_hi
        assign sel.ram_hi[g] = up_en && !addr_hi[TAG_W-2] &&
                               (addr_hi[HI_GRAN_W-1:0] == HI_GRAN_W'(g));
    end

    // R7: the top 16K never produces a window
    assert_top_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_hi[TAG_W-1 -: 2] == 2'b11) |-> (sel == '0));

    // R4: the I/O window decodes only at tag 01101
    assert_mmio_place_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sel.mmio |-> (addr_hi == 5'b01101));

endmodule

// File: rtl/mcd_strobe_qual.sv
// Module: qualifies the I/O window with the read and write strobes, delays
// the video write qualification by one clock, and optionally registers the outputs.
// Assumes: sel comes from the decode stages and is gated by the memory cycle.
module mcd_strobe_qual
    import mcd_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  sel_t             sel,
    input  logic             mreq_n,
    input  logic             iorq_n,
    input  logic             rd_n,
    input  logic             wr_n,
    output logic             rom0_cs_n,
    output logic             rom1_cs_n,
    output logic             cart_cs_n,
    output logic             mmio_rd_n,
    output logic             mmio_wr_n,
    output logic             vram_cs_n,
    output logic             vram_wr_n,
    output logic             ram_lo_cs_n,
    output logic [HI_GRAN-1:0] ram_hi_cs_n
);

    logic             vram_prev_q;
    logic [OUT_W-1:0] nxt_n;
    logic [OUT_W-1:0] out_n;

    // Purpose: remember whether the video window was decoded last clock
    always_ff @(posedge clk) begin
        if (!rst_n)
            vram_prev_q <= 1'b0;
        else
            vram_prev_q <= sel.vram;
    end

    // Purpose: qualify strobes and pack the active-low outputs
    always_comb begin
        nxt_n = ~{sel.rom0, sel.rom1, sel.cart,
                  sel.mmio && !rd_n, sel.mmio && !wr_n,
                  sel.vram, sel.vram && !wr_n && vram_prev_q,
                  sel.ram_lo, sel.ram_hi};
    end

    // Purpose: pick a registered or a direct output stage
    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n)
                out_n <= '1;
            else
                out_n <= nxt_n;
        end
    end else begin : g_comb
        assign out_n = nxt_n;
    end

    assign {rom0_cs_n, rom1_cs_n, cart_cs_n, mmio_rd_n, mmio_wr_n,
            vram_cs_n, vram_wr_n, ram_lo_cs_n, ram_hi_cs_n} = out_n;

    // R1: without a memory cycle the decode stages deliver no window
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mreq_n || !iorq_n) |-> (sel == '0));

    // R8: the video write strobe never leads the video select
    assert_vwr_after_cs_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !vram_wr_n |-> (!vram_cs_n && $past(!vram_cs_n)));

    // R10: at most one select is active on the outputs
    assert_one_select_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({!rom0_cs_n, !rom1_cs_n, !cart_cs_n, !(mmio_rd_n && mmio_wr_n),
                  !vram_cs_n, !ram_lo_cs_n, ~ram_hi_cs_n}));

endmodule

// File: rtl/mem_cs_decoder.sv
// Module: top of the memory-map chip-select decoder. It chains the block
// decode, the 2K sub-decode and the strobe qualification stages.
// Assumes: addr_hi carries A15..A11; all strobes are active low.
module mem_cs_decoder
    import mcd_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [TAG_W-1:0]   addr_hi,
    input  logic               mreq_n,
    input  logic               iorq_n,
    input  logic               rd_n,
    input  logic               wr_n,
    input  logic               m1_n,
    output logic               rom0_cs_n,
    output logic               rom1_cs_n,
    output logic               cart_cs_n,
    output logic               mmio_rd_n,
    output logic               mmio_wr_n,
    output logic               vram_cs_n,
    output logic               vram_wr_n,
    output logic               ram_lo_cs_n,
    output logic [HI_GRAN-1:0] ram_hi_cs_n
);

    cyc_e             cyc;
    logic [BLK_N-1:0] blk_en;
    logic             up_en;
    sel_t             sel;

    mcd_block_decode u_blk (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_hi (addr_hi),
        .mreq_n  (mreq_n),
        .iorq_n  (iorq_n),
        .rd_n    (rd_n),
        .wr_n    (wr_n),
        .m1_n    (m1_n),
        .cyc     (cyc),
        .blk_en  (blk_en),
        .up_en   (up_en)
    );

    mcd_sub_decode u_sub (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_hi (addr_hi),
        .blk_en  (blk_en),
        .up_en   (up_en),
        .sel     (sel)
    );

    mcd_strobe_qual #(.REG_OUT(REG_OUT)) u_qual (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel         (sel),
        .mreq_n      (mreq_n),
        .iorq_n      (iorq_n),
        .rd_n        (rd_n),
        .wr_n        (wr_n),
        .rom0_cs_n   (rom0_cs_n),
        .rom1_cs_n   (rom1_cs_n),
        .cart_cs_n   (cart_cs_n),
        .mmio_rd_n   (mmio_rd_n),
        .mmio_wr_n   (mmio_wr_n),
        .vram_cs_n   (vram_cs_n),
        .vram_wr_n   (vram_wr_n),
        .ram_lo_cs_n (ram_lo_cs_n),
        .ram_hi_cs_n (ram_hi_cs_n)
    );

    // R9: a fetch is classified apart from a read but opens the same windows
    assert_fetch_kind_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!mreq_n && iorq_n && wr_n && !rd_n && !m1_n) |-> (cyc == CYC_FETCH));

endmodule

// File: tb/tb_mem_cs_decoder.sv
// Bench: behavioural reference model of the memory map, compared on every clock.
module tb_mem_cs_decoder;

    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYCLES = 200000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] addr_hi = '0;
    logic       mreq_n = 1'b1, iorq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, m1_n = 1'b1;
    logic       rom0_cs_n, rom1_cs_n, cart_cs_n, mmio_rd_n, mmio_wr_n;
    logic       vram_cs_n, vram_wr_n, ram_lo_cs_n;
    logic [7:0] ram_hi_cs_n;

    int vectors = 0;
    int misses  = 0;
    bit done    = 1'b0;

    // values captured by the DUT at the most recent edge
    int  c_addr = 0, c_kind = 3;
    bit  c_rst = 1'b1;
    bit  prev_vram = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mem_cs_decoder dut (
        .clk(clk), .rst_n(rst_n), .addr_hi(addr_hi),
        .mreq_n(mreq_n), .iorq_n(iorq_n), .rd_n(rd_n), .wr_n(wr_n), .m1_n(m1_n),
        .rom0_cs_n(rom0_cs_n), .rom1_cs_n(rom1_cs_n), .cart_cs_n(cart_cs_n),
        .mmio_rd_n(mmio_rd_n), .mmio_wr_n(mmio_wr_n), .vram_cs_n(vram_cs_n),
        .vram_wr_n(vram_wr_n), .ram_lo_cs_n(ram_lo_cs_n), .ram_hi_cs_n(ram_hi_cs_n)
    );

    // kinds: 0 read, 1 write, 2 fetch, 3 idle, 4 I/O request, 5 refresh
    function automatic bit is_mem(int kind);
        return kind == 0 || kind == 1 || kind == 2 || kind == 5;
    endfunction

    function automatic bit in_vram(int tag, int kind);
        int a = tag * 2048;
        return is_mem(kind) && a >= 'h7000 && a < 'h7800;
    endfunction

    // Reference: active-low word {rom0,rom1,cart,mrd,mwr,vcs,vwr,rlo,rhi[7:0]}
    function automatic logic [15:0] model(int tag, int kind, bit pv);
        logic [15:0] w = '1;
        int a = tag * 2048;
        bit rd = (kind == 0 || kind == 2);
        bit wr = (kind == 1);
        if (is_mem(kind)) begin
            if (a < 'h2000)      w[15] = 1'b0;
            else if (a < 'h4000) w[14] = 1'b0;
            else if (a < 'h6800) w[13] = 1'b0;
            else if (a < 'h7000) begin
                if (rd) w[12] = 1'b0;
                if (wr) w[11] = 1'b0;
            end else if (a < 'h7800) begin
                w[10] = 1'b0;
                if (wr && pv) w[9] = 1'b0;
            end else if (a < 'h8000) w[8] = 1'b0;
            else if (a < 'hC000)  w[(a - 'h8000) / 2048] = 1'b0;
        end
        return w;
    endfunction

    function automatic string field_req(logic [15:0] diff);
        if (diff[15] || diff[14]) return "R2";
        if (diff[13])             return "R3";
        if (diff[12] || diff[11]) return "R4";
        if (diff[9])              return "R8";
        if (diff[10] || diff[8])  return "R5";
        return "R6";
    endfunction

    // One clock: check what the last edge produced, then drive the next inputs
    task automatic step(int tag, int kind, bit rst, string ctx);
        logic [15:0] act, exp;
        @(negedge clk);
        act = {rom0_cs_n, rom1_cs_n, cart_cs_n, mmio_rd_n, mmio_wr_n,
               vram_cs_n, vram_wr_n, ram_lo_cs_n, ram_hi_cs_n};
        exp = c_rst ? 16'hFFFF : model(c_addr, c_kind, prev_vram);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s/%s tag=%0d kind=%0d actual=%h expected=%h",
                     ctx, c_rst ? "R11" : field_req(act ^ exp), c_addr, c_kind, act, exp);
        end
        // R10: at most one select active among the outputs
        vectors++;
        if ($countones({~act[15:13], ~(act[12] & act[11]), ~act[10], ~act[8:0]}) > 1) begin
            misses++;
            $display("FAIL R10 several selects actual=%h expected=one-hot", act);
        end
        prev_vram = c_rst ? 1'b0 : in_vram(c_addr, c_kind);
        c_addr = tag; c_kind = kind; c_rst = rst;
        rst_n   = !rst;
        addr_hi = 5'(tag);
        mreq_n  = !is_mem(kind);
        iorq_n  = (kind != 4);
        rd_n    = !(kind == 0 || kind == 2);
        wr_n    = (kind != 1);
        m1_n    = (kind != 2);
    endtask

    initial begin
        // R11: reset holds every output high even with a video write applied
        step(14, 1, 1'b1, "R11 reset");
        step(14, 1, 1'b1, "R11 reset");
        step(14, 1, 1'b0, "R11 reset");
        // Sweep every tag under each cycle kind, each held for two clocks
        for (int kind = 0; kind < 6; kind++) begin
            for (int tag = 0; tag < 32; tag++) begin
                string ctx;
                case (kind)
                    0: ctx = "R2-read";
                    1: ctx = "R8 write";
                    2: ctx = "R9 fetch";
                    3: ctx = "R1 idle";
                    4: ctx = "R1 ioreq";
                    default: ctx = "R4 refresh";
                endcase
                if (tag >= 24) ctx = {ctx, " R7"};
                step(tag, kind, 1'b0, ctx);
                step(tag, kind, 1'b0, ctx);
            end
        end
        // R8/R11: reset in the middle of a held video write restarts the lag
        step(14, 1, 1'b0, "R8 vwr");
        step(14, 1, 1'b0, "R8 vwr");
        step(14, 1, 1'b1, "R11 midreset");
        step(14, 1, 1'b0, "R8 after reset");
        step(14, 1, 1'b0, "R8 after reset");
        step(14, 1, 1'b0, "R8 after reset");
        // R8: read of video then write gives the strobe at once
        step(14, 0, 1'b0, "R8 rd-then-wr");
        step(14, 1, 1'b0, "R8 rd-then-wr");
        step(3, 3, 1'b0, "R1 idle");
        step(3, 3, 1'b0, "R1 idle");
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still prints the summary
    initial begin
        repeat (MAX_CYCLES) @(posedge clk);
        if (!done) begin
            misses++;
            $display("FAIL watchdog R11 actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

endmodule